// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two USB data line levels, already brought into the system clock domain, and recognises a bus reset. A bus reset is a single-ended zero (SE0), meaning both lines are low at once, that lasts longer than a minimum time. The block counts consecutive SE0 samples in system clock cycles. When the count reaches a threshold derived from the clock frequency, the block raises a one-cycle event.

On the same clock edge as the event, the block also sets a sticky flag. Surrounding logic can feed the event into an interrupt request and the flag into the bus-reset bit of a status register. The block never resets anything itself. It only reports the condition. Software or control logic clears the flag through a clear input.

The threshold is `CLK_KHZ * MIN_SE0_NS / 1_000_000 + 1` cycles. This is the first sample count that lasts strictly longer than the minimum. With the defaults (1000 kHz, 8000 ns) the threshold is 9 cycles.

Top module: `usb_bus_reset_detect`

## Requirements
- R1: A sample counts as SE0 only when `line_dp` and `line_dm` are both 0. The samples (1,0), (0,1) and (1,1) are not SE0.
- R2: `bus_reset_pulse` is 1 in the cycle that follows the clock edge sampling the THRESH-th consecutive SE0 (9 with the defaults). A run of THRESH-1 SE0 samples produces no event.
- R3: `bus_reset_pulse` is never high for two cycles in a row.
- R4: A continuous SE0 produces exactly one event, however long it lasts.
- R5: Any sample that is not SE0 restarts the duration count from zero. A later SE0 run needs THRESH fresh samples.
- R6: `bus_reset_flag` becomes 1 on the same edge as the event and stays 1 until a clear or a reset. It never rises without an event.
- R7: `flag_clr` sampled high clears the flag on that edge. If an event occurs on the same edge, the flag stays set.
- R8: With `rst_n` sampled low (synchronous, active low), the counter, the event and the flag all go to 0. After release, a new SE0 run needs THRESH samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_dp | input | 1 | Synchronised D+ level |
| line_dm | input | 1 | Synchronised D- level |
| flag_clr | input | 1 | Clears the sticky bus-reset flag |
| bus_reset_pulse | output | 1 | One-cycle bus-reset event |
| bus_reset_flag | output | 1 | Sticky bus-reset indication |

## Verification
The assertions assume the line inputs are already synchronous to `clk` and hold one value per cycle. Each sample is therefore taken as a clean level, with no glitch or metastable value between edges. The stimulus changes the lines and `flag_clr` only on falling edges and holds each value across a full rising edge. Runs are built from whole cycles, so the run length that the checker counts is exactly the run length the bench intends.

// File: rtl/usb_rst_pkg.sv
// Package: shared constants and helpers for the bus reset detector.
// Assumes integer arithmetic on clock kHz times ns stays within 32 bits.
package usb_rst_pkg;

    // Number of consecutive SE0 cycles that strictly exceed min_ns.
    function automatic int unsigned se0_thresh(input int unsigned clk_khz,
                                               input int unsigned min_ns);
        return (clk_khz * min_ns) / 1_000_000 + 1;
    endfunction

    // Line state seen on the data pair.
    typedef enum logic [1:0] {
        LINE_SE0 = 2'b00,
        LINE_K   = 2'b01,
        LINE_J   = 2'b10,
        LINE_SE1 = 2'b11
    } line_state_e;

endpackage

// File: rtl/se0_line_decode.sv
// Module: classifies the sampled data pair into a line state and flags SE0.
// Assumes both inputs are already synchronous to the consuming clock.
module se0_line_decode
    import usb_rst_pkg::*;
(
    input  logic        dp,
    input  logic        dm,
    output line_state_e state,
    output logic        is_se0
);

    // Decode the pair; SE0 only when both lines are low.
    always_comb begin
        state  = line_state_e'({dp, dm});
        is_se0 = (state == LINE_SE0);
    end

endmodule

// File: rtl/se0_run_counter.sv
// Module: counts consecutive SE0 cycles, saturating at THRESH, and flags
// the single cycle in which the count first reaches THRESH.
// Assumes a synchronous active-low reset and THRESH >= 1.
module se0_run_counter #(
    parameter int unsigned THRESH = 9,
    localparam int unsigned CNT_W = (THRESH < 2) ? 1 : $clog2(THRESH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se0,
    output logic hit
);

    localparam logic [CNT_W-1:0] LAST_BELOW = CNT_W'(THRESH - 1);
    localparam logic [CNT_W-1:0] TOP        = CNT_W'(THRESH);

    logic [CNT_W-1:0] run_q;

    // Crossing detect: this SE0 sample is the THRESH-th of the run.
    always_comb hit = se0 && (run_q == LAST_BELOW);

    // Run length register: clear on non-SE0, count up, hold at THRESH.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (!se0)       run_q <= '0;
        else if (run_q != TOP) run_q <= run_q + 1'b1;
    end

endmodule

// File: rtl/reset_event_latch.sv
// Module: registers the crossing into a one-cycle event and keeps a sticky
// flag that a clear input drops; a simultaneous set wins over the clear.
// Assumes hit lasts at most one cycle per SE0 run.
module reset_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic evt,
    output logic flag
);

    // Event register: one cycle per crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= hit;
    end

    // Sticky flag: set by crossing, cleared by clr, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (hit)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

endmodule

// File: rtl/usb_bus_reset_detect.sv
// Module: top of the bus reset detector. Qualifies SE0 by duration and
// reports a pulse plus a sticky flag; it never resets anything itself.
// Assumes line_dp/line_dm are already synchronised to clk.
module usb_bus_reset_detect
    import usb_rst_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 1000,
    parameter int unsigned MIN_SE0_NS = 8000,
    localparam int unsigned THRESH    = se0_thresh(CLK_KHZ, MIN_SE0_NS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_dp,
    input  logic line_dm,
    input  logic flag_clr,
    output logic bus_reset_pulse,
    output logic bus_reset_flag
);

    line_state_e line_state;
    logic        se0;
    logic        crossing;

    se0_line_decode u_decode (
        .dp     (line_dp),
        .dm     (line_dm),
        .state  (line_state),
        .is_se0 (se0)
    );

    se0_run_counter #(.THRESH(THRESH)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .se0   (se0),
        .hit   (crossing)
    );

    reset_event_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (crossing),
        .clr   (flag_clr),
        .evt   (bus_reset_pulse),
        .flag  (bus_reset_flag)
    );

endmodule

// File: rtl/usb_bus_reset_detect_chk.sv
// Module: property checker for the bus reset detector, bound to the top.
// Keeps its own SE0 run length from the ports and relates outputs to it.
module usb_bus_reset_detect_chk #(
    parameter int unsigned THRESH = 9
) (
    input logic clk,
    input logic rst_n,
    input logic line_dp,
    input logic line_dm,
    input logic flag_clr,
    input logic bus_reset_pulse,
    input logic bus_reset_flag
);

    int unsigned chk_run;

    // Observer run length, saturating above THRESH.
    always_ff @(posedge clk) begin
        if (!rst_n)                    chk_run <= 0;
        else if (line_dp || line_dm)   chk_run <= 0;
        else if (chk_run <= THRESH)    chk_run <= chk_run + 1;
    end

    // R2
    evt_at_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_pulse |-> (chk_run == THRESH));

    // R4
    thresh_gives_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_run == THRESH) |-> bus_reset_pulse);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_pulse |=> !bus_reset_pulse);

    // R1
    idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_dp || line_dm) |=> !bus_reset_pulse);

    // R6
    flag_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_pulse |-> bus_reset_flag);

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_reset_flag) |-> bus_reset_pulse);

    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_reset_flag) |-> ($past(flag_clr) || !$past(rst_n)));

endmodule

bind usb_bus_reset_detect usb_bus_reset_detect_chk #(.THRESH(THRESH)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .line_dp         (line_dp),
    .line_dm         (line_dm),
    .flag_clr        (flag_clr),
    .bus_reset_pulse (bus_reset_pulse),
    .bus_reset_flag  (bus_reset_flag)
);

// File: tb/usb_bus_reset_detect_tb_top.sv
// Bench: vector table walk, then directed reset and corner-case tests.
module usb_bus_reset_detect_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int THR        = 9;

    logic clk = 1'b0;
    logic rst_n, line_dp, line_dm, flag_clr;
    logic bus_reset_pulse, bus_reset_flag;
    int   checks = 0;
    int   errors = 0;
    int   evt_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bus_reset_detect dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_dp         (line_dp),
        .line_dm         (line_dm),
        .flag_clr        (flag_clr),
        .bus_reset_pulse (bus_reset_pulse),
        .bus_reset_flag  (bus_reset_flag)
    );

    // Vector fields: {dp, dm, clr, expected pulse, expected flag} after the edge.
    localparam logic [4:0] VEC [24] = '{
        5'b10000,                                         // J idle (R1)
        5'b00000, 5'b00000, 5'b00000, 5'b00000,           // SE0 1..4
        5'b00000, 5'b00000, 5'b00000, 5'b00000,           // SE0 5..8, no event (R2)
        5'b10000,                                         // J restarts count (R5)
        5'b00000, 5'b00000, 5'b00000, 5'b00000,           // SE0 1..4
        5'b00000, 5'b00000, 5'b00000, 5'b00000,           // SE0 5..8
        5'b00011,                                         // SE0 9th: event + flag (R2, R6)
        5'b00001, 5'b00001,                               // no repeat, flag held (R3, R4, R6)
        5'b01001,                                         // K, flag held (R1, R6)
        5'b10100,                                         // clear (R7)
        5'b11000                                          // SE1 not SE0 (R1)
    };

    task automatic apply(input logic dp_i, input logic dm_i,
                         input logic clr_i, input logic rst_i);
        @(negedge clk);
        line_dp  = dp_i;
        line_dm  = dm_i;
        flag_clr = clr_i;
        rst_n    = rst_i;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (bus_reset_pulse) evt_count++;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic se0_run(input int n);
        for (int i = 0; i < n; i++) apply(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        evt_count = 0;
        // R8: reset state
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 pulse after reset", bus_reset_pulse, 1'b0);
        check("R8 flag after reset", bus_reset_flag, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b1);

        // Table walk
        for (int v = 0; v < 24; v++) begin
            apply(VEC[v][4], VEC[v][3], VEC[v][2], 1'b1);
            check($sformatf("R1-R7 vec%0d pulse", v), bus_reset_pulse, VEC[v][1]);
            check($sformatf("R6/R7 vec%0d flag", v), bus_reset_flag, VEC[v][0]);
        end

        // R8: reset mid-run clears the counter
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        se0_run(5);
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 pulse in reset", bus_reset_pulse, 1'b0);
        se0_run(THR - 1);
        check("R8 no early event after reset", bus_reset_pulse, 1'b0);
        se0_run(1);
        check("R8 event after full run", bus_reset_pulse, 1'b1);
        check("R8 flag set", bus_reset_flag, 1'b1);

        // R8: reset clears a set flag
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 flag cleared by reset", bus_reset_flag, 1'b0);

        // R4: long SE0 gives one event
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        evt_count = 0;
        se0_run(300);
        checks++;
        if (evt_count != 1) begin
            errors++;
            $display("FAIL R4 long SE0 events: got %0d expected 1", evt_count);
        end

        // R7: clear during ongoing SE0 stays cleared
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        check("R7 clear during SE0", bus_reset_flag, 1'b0);
        se0_run(20);
        check("R7 flag not re-set", bus_reset_flag, 1'b0);

        // R7: set wins over simultaneous clear
        apply(1'b0, 1'b1, 1'b0, 1'b1);
        se0_run(THR - 1);
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        check("R7 set wins pulse", bus_reset_pulse, 1'b1);
        check("R7 set wins flag", bus_reset_flag, 1'b1);
        apply(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3 pulse drops", bus_reset_pulse, 1'b0);

        // R5: single idle sample inside a long run restarts the count
        apply(1'b1, 1'b1, 1'b1, 1'b1);
        se0_run(THR - 1);
        apply(1'b0, 1'b1, 1'b0, 1'b1);
        se0_run(THR - 1);
        check("R5 broken run no event", bus_reset_pulse, 1'b0);
        check("R5 broken run no flag", bus_reset_flag, 1'b0);
        se0_run(1);
        check("R5 fresh run event", bus_reset_pulse, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule